// File: doc/BRIEF.md
# Bus Hold Acknowledge Controller

This block sits beside a bus master's bus unit. It decides when another local-bus master may take the bus. An external agent raises an active-high hold request. The controller waits until the bus unit reports that nothing is in flight: no single cycle, no burst and no locked sequence. Only then does it release the bus. Release means raising the hold acknowledge and, in the same clock, turning on the float enable for the master's address, data and control pins. The bus stays released for as long as the hold request remains high. One clock after the request drops, the pins are driven again and the acknowledge falls.

The controller also owns the small queue of internal bus requests. Each request arrives as a one-clock push pulse and waits as a pending entry until a cycle start hands it to the bus unit. The bus-request output is always driven, even while the pins float, and it shows whether any request is pending. While the bus is held, requests keep queueing but no cycle is launched. An optional synchronizer for the hold input is selected by a parameter.

Top module: `bus_hold_ctrl`

## Requirements
- R1: While reset is asserted, and directly after it, hold acknowledge is 0, pin float is 0, bus request is 0 and no cycle start is issued.
- R2: Acknowledge rises only on a clock edge at which the hold request was 1 and the cycle-busy, burst-busy and lock-sequence inputs were all 0. It becomes visible one clock after that edge.
- R3: Acknowledge and pin float are equal on every clock. Both change on the same edge.
- R4: Once acknowledge is 1, it stays 1 as long as the hold request remains 1, whatever the bus-status and push inputs do.
- R5: If the hold request is 0 at an edge while acknowledge is 1, acknowledge and pin float are both 0 after that edge.
- R6: Bus request is 1 exactly when at least one internal request is pending. This holds while the bus is released as well.
- R7: No cycle start is issued while acknowledge is 1. Pushes made during that time are kept pending.
- R8: While the hold request is 1 and the lock-sequence input is 0, no new cycle starts. While the lock-sequence input is 1, starts may continue despite the hold request.
- R9: At most DEPTH requests (default 4) are pending. A push arriving when DEPTH are already pending and no start occurs is dropped.
- R10: A cycle start is issued when acknowledge is 0, a request is pending, and cycle-busy and burst-busy are both 0, subject to R8. Each start consumes exactly one pending request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hold_req_i | input | 1 | Hold request from another bus master, active high |
| cyc_busy_i | input | 1 | Bus unit has a bus cycle in progress |
| burst_busy_i | input | 1 | Bus unit is inside a burst |
| lock_seq_i | input | 1 | Bus unit is inside a locked sequence, including gaps between its cycles |
| req_push_i | input | 1 | One-clock pulse adding an internal bus request |
| cyc_start_o | output | 1 | Hands one pending request to the bus unit this clock |
| bus_req_o | output | 1 | Pending-request indication, never floated |
| hold_ack_o | output | 1 | Hold acknowledge, active high |
| pin_float_o | output | 1 | Float enable for address, data and control pins |

## Verification
The hardest situation to reach is overflow of the pending queue. Starts consume requests as quickly as they arrive, so pushing from the ports alone never fills it. The stimulus therefore first takes the bus away with a hold request, which blocks every start. It then pushes more requests than the queue can hold and releases the bus. It counts the starts that follow on an idle bus and expects exactly DEPTH. A second hard case is a hold request raised inside a locked sequence. A start is still expected there, and the acknowledge must wait until the lock indication drops.

// File: rtl/bhk_pkg.sv
package bhk_pkg;

   typedef enum logic {
      BUS_OWNED    = 1'b0,
      BUS_RELEASED = 1'b1
   } own_e;

   function automatic int unsigned cnt_width(input int unsigned depth);
      return $clog2(depth + 1);
   endfunction

endpackage

// File: rtl/bhk_hold_sync.sv
module bhk_hold_sync #(
   parameter int unsigned STAGES = 0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic hold_i,
   output logic hold_o
);

   generate
      if (STAGES > 4) begin : g_bad_stages
         $error("bhk_hold_sync: STAGES must be 0..4");
      end

      if (STAGES == 0) begin : g_direct
         assign hold_o = hold_i;
      end else begin : g_chain
         logic [STAGES-1:0] shreg;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               shreg <= '0;
            end else begin
               shreg[0] <= hold_i;
               for (int i = 1; i < int'(STAGES); i++) begin
                  shreg[i] <= shreg[i-1];
               end
            end
         end

         assign hold_o = shreg[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/bhk_req_queue.sv
module bhk_req_queue #(
   parameter int unsigned DEPTH = 4,
   localparam int unsigned CW = bhk_pkg::cnt_width(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push_i,
   input  logic          pop_i,
   output logic          pending_o,
   output logic [CW-1:0] count_o
);

   localparam logic [CW-1:0] LIMIT = CW'(DEPTH);

   generate
      if (DEPTH < 1) begin : g_bad_depth
         $error("bhk_req_queue: DEPTH must be at least 1");
      end
   endgenerate

   logic [CW-1:0] cnt_q;
   logic [CW-1:0] cnt_d;
   logic          full;
   logic          accept;

   assign full   = (cnt_q == LIMIT);
   assign accept = push_i && (!full || pop_i);

   always_comb begin
      cnt_d = cnt_q;
      unique case ({accept, pop_i})
         2'b10:   cnt_d = cnt_q + CW'(1);
         2'b01:   cnt_d = cnt_q - CW'(1);
         default: cnt_d = cnt_q;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_d;
      end
   end

   assign pending_o = (cnt_q != '0);
   assign count_o   = cnt_q;

   // R9: the pending count never passes the configured depth
   p_cap_r9: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= LIMIT);

   // R10: a start only takes an entry that exists
   p_pop_pending_r10: assert property (@(posedge clk) disable iff (!rst_n)
      pop_i |-> (cnt_q != '0));

   // R10: each start without a push removes exactly one entry
   p_pop_one_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (pop_i && !push_i) |=> (cnt_q == $past(cnt_q) - CW'(1)));

endmodule

// File: rtl/bhk_hold_fsm.sv
module bhk_hold_fsm (
   input  logic clk,
   input  logic rst_n,
   input  logic hold_i,
   input  logic cyc_busy_i,
   input  logic burst_busy_i,
   input  logic lock_seq_i,
   input  logic start_i,
   output logic ack_o,
   output logic release_next_o
);
   import bhk_pkg::*;

   own_e state_q;
   own_e state_d;
   logic quiet;

   assign quiet = !cyc_busy_i && !burst_busy_i && !lock_seq_i && !start_i;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         BUS_OWNED: begin
            if (hold_i && quiet) begin
               state_d = BUS_RELEASED;
            end
         end
         BUS_RELEASED: begin
            if (!hold_i) begin
               state_d = BUS_OWNED;
            end
         end
         default: state_d = BUS_OWNED;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= BUS_OWNED;
      end else begin
         state_q <= state_d;
      end
   end

   assign ack_o          = (state_q == BUS_RELEASED);
   assign release_next_o = (state_d == BUS_RELEASED);

   // R2: the bus is handed over only once every transaction kind has ended
   p_grant_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ack_o) |-> $past(hold_i && !cyc_busy_i && !burst_busy_i && !lock_seq_i));

   // R4: the bus stays released while the request persists
   p_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_o && hold_i) |=> ack_o);

   // R5: dropping the request returns the bus on the next clock
   p_return_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_o && !hold_i) |=> !ack_o);

endmodule

// File: rtl/bhk_pin_ctl.sv
module bhk_pin_ctl (
   input  logic clk,
   input  logic rst_n,
   input  logic release_next_i,
   output logic float_o
);

   logic float_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         float_q <= 1'b0;
      end else begin
         float_q <= release_next_i;
      end
   end

   assign float_o = float_q;

endmodule

// File: rtl/bus_hold_ctrl.sv
module bus_hold_ctrl #(
   parameter int unsigned DEPTH       = 4,
   parameter int unsigned SYNC_STAGES = 0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic hold_req_i,
   input  logic cyc_busy_i,
   input  logic burst_busy_i,
   input  logic lock_seq_i,
   input  logic req_push_i,
   output logic cyc_start_o,
   output logic bus_req_o,
   output logic hold_ack_o,
   output logic pin_float_o
);

   localparam int unsigned CW = bhk_pkg::cnt_width(DEPTH);

   logic          hold_s;
   logic          ack;
   logic          release_next;
   logic          pending;
   logic          start;
   logic          bus_idle;
   logic          hold_blocks;
   logic [CW-1:0] pend_cnt;

   bhk_hold_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .hold_i (hold_req_i),
      .hold_o (hold_s)
   );

   assign bus_idle    = !cyc_busy_i && !burst_busy_i;
   assign hold_blocks = hold_s && !lock_seq_i;
   assign start       = !ack && pending && bus_idle && !hold_blocks;

   bhk_req_queue #(.DEPTH(DEPTH)) u_queue (
      .clk       (clk),
      .rst_n     (rst_n),
      .push_i    (req_push_i),
      .pop_i     (start),
      .pending_o (pending),
      .count_o   (pend_cnt)
   );

   bhk_hold_fsm u_fsm (
      .clk            (clk),
      .rst_n          (rst_n),
      .hold_i         (hold_s),
      .cyc_busy_i     (cyc_busy_i),
      .burst_busy_i   (burst_busy_i),
      .lock_seq_i     (lock_seq_i),
      .start_i        (start),
      .ack_o          (ack),
      .release_next_o (release_next)
   );

   bhk_pin_ctl u_pins (
      .clk            (clk),
      .rst_n          (rst_n),
      .release_next_i (release_next),
      .float_o        (pin_float_o)
   );

   assign cyc_start_o = start;
   assign bus_req_o   = pending;
   assign hold_ack_o  = ack;

   // R3: acknowledge and pin float come from separate registers and must agree
   p_ack_float_r3: assert property (@(posedge clk) disable iff (!rst_n)
      hold_ack_o == pin_float_o);

   // R7: nothing is launched while another master owns the bus
   p_no_start_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
      hold_ack_o |-> !cyc_start_o);

   // R8: a pending hold outside a locked sequence stops new starts
   p_hold_drain_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (hold_s && !lock_seq_i) |-> !cyc_start_o);

   // R6: the request indication tracks the pending count
   p_breq_r6: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req_o == (pend_cnt != '0));

endmodule

// File: tb/sim_bus_hold_ctrl.sv
`timescale 1ns/1ps
module sim_bus_hold_ctrl;

   localparam int DEPTH = 4;
   localparam time PERIOD = 20ns;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic hold_req_i = 1'b0, cyc_busy_i = 1'b0, burst_busy_i = 1'b0;
   logic lock_seq_i = 1'b0, req_push_i = 1'b0;
   logic cyc_start_o, bus_req_o, hold_ack_o, pin_float_o;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #(PERIOD/2) clk = ~clk;

   bus_hold_ctrl #(.DEPTH(DEPTH), .SYNC_STAGES(0)) u0 (
      .clk(clk), .rst_n(rst_n), .hold_req_i(hold_req_i), .cyc_busy_i(cyc_busy_i),
      .burst_busy_i(burst_busy_i), .lock_seq_i(lock_seq_i), .req_push_i(req_push_i),
      .cyc_start_o(cyc_start_o), .bus_req_o(bus_req_o), .hold_ack_o(hold_ack_o),
      .pin_float_o(pin_float_o)
   );

   // {hold, busy, burst, lock, push, exp_start, exp_ack, exp_breq}
   localparam logic [7:0] VEC [13] = '{
      8'b00001_001, 8'b00000_100, 8'b11000_000, 8'b10100_000,
      8'b10010_000, 8'b10001_011, 8'b10001_011, 8'b00000_001,
      8'b00000_101, 8'b10010_100, 8'b11010_000, 8'b10000_010,
      8'b00000_000
   };

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic drive(input logic h, b, u, l, p);
      @(negedge clk);
      hold_req_i = h; cyc_busy_i = b; burst_busy_i = u; lock_seq_i = l; req_push_i = p;
      #1;
   endtask

   task automatic after_edge();
      @(posedge clk);
      #1;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      hold_req_i = 0; cyc_busy_i = 0; burst_busy_i = 0; lock_seq_i = 0; req_push_i = 0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   initial begin
      #(PERIOD * 200000);
      if (!done) begin
         failures++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      int starts;
      // R1: reset state
      #1;
      check("R1 ack in reset", hold_ack_o, 0);
      check("R1 float in reset", pin_float_o, 0);
      check("R1 breq in reset", bus_req_o, 0);
      check("R1 start in reset", cyc_start_o, 0);
      do_reset();

      // vector walk: R2 R3 R4 R5 R6 R7 R8 R10
      for (int i = 0; i < 13; i++) begin
         drive(VEC[i][7], VEC[i][6], VEC[i][5], VEC[i][4], VEC[i][3]);
         check($sformatf("R10/R8 start row %0d", i), cyc_start_o, VEC[i][2]);
         after_edge();
         check($sformatf("R2/R5 ack row %0d", i), hold_ack_o, VEC[i][1]);
         check($sformatf("R3 float row %0d", i), pin_float_o, VEC[i][1]);
         check($sformatf("R6 breq row %0d", i), bus_req_o, VEC[i][0]);
      end

      // R9 overflow: take the bus, push beyond depth, release, count starts
      do_reset();
      drive(1, 0, 0, 0, 0);
      after_edge();
      check("R2 ack taken", hold_ack_o, 1);
      for (int k = 0; k < DEPTH + 2; k++) begin
         drive(1, k[0], k[1], 0, 1);
         check("R7 no start while held", cyc_start_o, 0);
         after_edge();
         check("R4 ack kept", hold_ack_o, 1);
         check("R6 breq while held", bus_req_o, 1);
      end
      drive(0, 0, 0, 0, 0);
      after_edge();
      check("R5 ack dropped", hold_ack_o, 0);
      check("R5 float dropped", pin_float_o, 0);
      starts = 0;
      for (int k = 0; k < 8; k++) begin
         drive(0, 0, 0, 0, 0);
         if (cyc_start_o) starts++;
         after_edge();
      end
      check("R9 starts after overflow", starts, DEPTH);
      check("R6 breq empty", bus_req_o, 0);

      // R10: busy bus holds back a pending start
      drive(0, 0, 0, 0, 1);
      after_edge();
      drive(0, 0, 1, 0, 0);
      check("R10 no start in burst", cyc_start_o, 0);
      drive(0, 0, 0, 0, 0);
      check("R10 start when idle", cyc_start_o, 1);
      after_edge();
      check("R10 entry consumed", bus_req_o, 0);

      // R1: reset while released
      drive(1, 0, 0, 0, 0);
      after_edge();
      check("R2 ack before reset", hold_ack_o, 1);
      @(negedge clk);
      rst_n = 1'b0;
      #1;
      check("R1 ack reset mid-hold", hold_ack_o, 0);
      check("R1 float reset mid-hold", pin_float_o, 0);
      hold_req_i = 0;
      @(negedge clk);
      rst_n = 1'b1;

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule